// File: doc/BRIEF.md
# In-Band Loopback Code Detector

This block monitors a serial receive bit stream for the two repeating in-band loopback codes used on digital lines. The loop-up code repeats `00001` and the loop-down code repeats `001`. A code counts as present only while every received bit keeps the repeating pattern. It counts as qualified only after it has been present without a break for more than a programmable number of one-second timebase ticks.

The block has three operating modes, chosen by a 2-bit select.

- **Off:** reporting and loopback control are off.
- **Manual:** the detect status follows whether a qualified code is arriving at that moment.
- **Automatic:** a qualified loop-up code latches a remote-loopback request. The request holds until a qualified loop-down code releases it. While the request is active, the detect status reads high.

Every change of the detect status can raise a one-cycle interrupt pulse.

Top module: `loopcode_detect`

## Requirements
- R1: After a synchronous reset, `det_status`, `rloop_en` and `irq_pulse` are all 0.
- R2: The loop-up pattern is the bit sequence 0,0,0,0,1 repeated, accepted at any bit phase. It qualifies only when more than `QUAL_SECS` ticks of `sec_tick` arrive while it is continuously present. Exactly `QUAL_SECS` ticks is not enough.
- R3: The loop-down pattern is the bit sequence 0,0,1 repeated, accepted at any bit phase. It qualifies under the same tick rule as R2.
- R4: A received bit that breaks the pattern restarts that pattern's tick count from zero.
- R5: With `mode_sel` = 2'b01 or 2'b10 (manual), `det_status` is 1 while either code is qualified. It returns to 0 within a few cycles of the code stopping. `rloop_en` stays 0.
- R6: When `irq_en` = 1, every rising or falling change of `det_status` comes with a one-cycle `irq_pulse` in the same cycle. When `irq_en` = 0, `irq_pulse` stays 0.
- R7: On entry to automatic mode (`mode_sel` = 2'b11), `det_status` and `rloop_en` clear. While loopback is inactive, a qualified loop-down code has no effect.
- R8: In automatic mode, a qualified loop-up code sets `rloop_en` and `det_status` together. Both stay set after the loop-up code stops.
- R9: In automatic mode with loopback active, a qualified loop-down code clears `rloop_en` and `det_status` together.
- R10: With `mode_sel` = 2'b00, `det_status` and `rloop_en` are held at 0 and both tick counts are cleared. `rloop_en` is never 1 in a cycle after `mode_sel` leaves 2'b11.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rx_bit | input | 1 | Received data bit |
| rx_valid | input | 1 | Qualifies `rx_bit` for this cycle |
| mode_sel | input | 2 | 00 off, 01/10 manual, 11 automatic |
| irq_en | input | 1 | Enables interrupt pulses |
| sec_tick | input | 1 | One-cycle pulse per second of timebase |
| det_status | output | 1 | Loop code detect status |
| rloop_en | output | 1 | Remote loopback request |
| irq_pulse | output | 1 | One-cycle interrupt on a status change |

## Verification
The bench builds the block with `QUAL_SECS` = 2. Each second tick is driven by hand, so the boundary between two ticks (not qualified) and three ticks (qualified) is reached in a few hundred cycles rather than billions. A short qualification window also lets one run cover several things:

- both manual select codes;
- a mid-count pattern break;
- the automatic latch-and-release sequence;
- mode exits while the loopback is latched.

// File: rtl/loopcode_pkg.sv
package loopcode_pkg;
  typedef enum logic [1:0] {
    MODE_OFF   = 2'b00,
    MODE_MAN_A = 2'b01,
    MODE_MAN_B = 2'b10,
    MODE_AUTO  = 2'b11
  } lc_mode_e;

  localparam int UP_LEN = 5;
  localparam int DN_LEN = 3;
  localparam logic [UP_LEN-1:0] UP_CODE = 5'b00001;
  localparam logic [DN_LEN-1:0] DN_CODE = 3'b001;
endpackage

// File: rtl/lc_pattern_match.sv
module lc_pattern_match #(
  parameter int PERIOD = 5,
  parameter logic [PERIOD-1:0] PATTERN = '0
) (
  input  logic clk,
  input  logic rst,
  input  logic bit_in,
  input  logic bit_vld,
  output logic present
);
  localparam int FW = $clog2(PERIOD + 1);

  logic [PERIOD-1:0] hist;
  logic [PERIOD-1:0] win;
  logic [FW-1:0]     fill;
  logic [PERIOD-1:0] rot_hit;

  assign win = {hist[PERIOD-2:0], bit_in};

  // A window equal to any rotation of the code means the newest bit repeats
  // the one PERIOD positions back and the phase is consistent.
  for (genvar r = 0; r < PERIOD; r++) begin : g_rot
    localparam logic [PERIOD-1:0] ROT = (PATTERN << r) | (PATTERN >> (PERIOD - r));
    assign rot_hit[r] = (win == ROT);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      hist    <= '0;
      fill    <= '0;
      present <= 1'b0;
    end else if (bit_vld) begin
      hist <= win;
      if (fill != FW'(PERIOD)) fill <= fill + 1'b1;
      present <= (fill >= FW'(PERIOD - 1)) && (|rot_hit);
    end
  end

  // R4
  present_after_fill_chk: assert property (@(posedge clk) disable iff (rst)
    present |-> (fill >= FW'(PERIOD - 1)));
endmodule

// File: rtl/lc_qual_timer.sv
module lc_qual_timer #(
  parameter int QUAL_SECS = 5
) (
  input  logic clk,
  input  logic rst,
  input  logic clr,
  input  logic present,
  input  logic tick,
  output logic qualified
);
  localparam int CW  = $clog2(QUAL_SECS + 2);
  localparam logic [CW-1:0] SAT = CW'(QUAL_SECS + 1);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst || clr || !present) cnt <= '0;
    else if (tick && cnt != SAT) cnt <= cnt + 1'b1;
  end

  assign qualified = (cnt > CW'(QUAL_SECS));

  // R2
  timer_sat_chk: assert property (@(posedge clk) disable iff (rst)
    cnt <= SAT);
  // R4
  absent_restart_chk: assert property (@(posedge clk) disable iff (rst)
    !present |=> (cnt == '0));
endmodule

// File: rtl/lc_ctrl.sv
module lc_ctrl
  import loopcode_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic [1:0] mode_sel,
  input  logic       irq_en,
  input  logic       up_qual,
  input  logic       dn_qual,
  output logic       tmr_clr,
  output logic       status,
  output logic       loop_on,
  output logic       irq
);
  lc_mode_e mode_q, mode_n;
  logic     entering_auto, loop_set, loop_clr;
  logic     status_n, loop_n;

  assign mode_n        = lc_mode_e'(mode_sel);
  assign entering_auto = (mode_n == MODE_AUTO) && (mode_q != MODE_AUTO);
  assign loop_set      = (mode_n == MODE_AUTO) && !entering_auto && !loop_on && up_qual;
  assign loop_clr      = (mode_n == MODE_AUTO) && !entering_auto && loop_on && dn_qual;
  assign tmr_clr       = (mode_n == MODE_OFF) || (mode_n != mode_q) || loop_set || loop_clr;

  always_comb begin
    status_n = status;
    loop_n   = loop_on;
    unique case (mode_n)
      MODE_OFF: begin
        status_n = 1'b0;
        loop_n   = 1'b0;
      end
      MODE_MAN_A, MODE_MAN_B: begin
        status_n = up_qual | dn_qual;
        loop_n   = 1'b0;
      end
      MODE_AUTO: begin
        if (entering_auto) begin
          status_n = 1'b0;
          loop_n   = 1'b0;
        end else if (loop_set) begin
          status_n = 1'b1;
          loop_n   = 1'b1;
        end else if (loop_clr) begin
          status_n = 1'b0;
          loop_n   = 1'b0;
        end
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      mode_q  <= MODE_OFF;
      status  <= 1'b0;
      loop_on <= 1'b0;
      irq     <= 1'b0;
    end else begin
      mode_q  <= mode_n;
      status  <= status_n;
      loop_on <= loop_n;
      irq     <= irq_en && (status_n != status);
    end
  end

  // R10
  loop_only_auto_chk: assert property (@(posedge clk) disable iff (rst)
    (mode_sel != 2'b11) |=> !loop_on);
  // R10
  off_holds_zero_chk: assert property (@(posedge clk) disable iff (rst)
    (mode_sel == 2'b00) |=> (!status && !loop_on));
  // R8
  loop_implies_status_chk: assert property (@(posedge clk) disable iff (rst)
    loop_on |-> status);
  // R6
  irq_on_change_chk: assert property (@(posedge clk) disable iff (rst)
    irq |-> (status != $past(status)));
  // R7
  auto_entry_clear_chk: assert property (@(posedge clk) disable iff (rst)
    ((mode_sel == 2'b11) && (mode_q != MODE_AUTO)) |=> (!status && !loop_on));
endmodule

// File: rtl/loopcode_detect.sv
module loopcode_detect
  import loopcode_pkg::*;
#(
  parameter int QUAL_SECS = 5
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       rx_bit,
  input  logic       rx_valid,
  input  logic [1:0] mode_sel,
  input  logic       irq_en,
  input  logic       sec_tick,
  output logic       det_status,
  output logic       rloop_en,
  output logic       irq_pulse
);
  logic up_pres, dn_pres, up_qual, dn_qual, tmr_clr;

  lc_pattern_match #(.PERIOD(UP_LEN), .PATTERN(UP_CODE)) u_up_match (
    .clk(clk), .rst(rst), .bit_in(rx_bit), .bit_vld(rx_valid), .present(up_pres));

  lc_pattern_match #(.PERIOD(DN_LEN), .PATTERN(DN_CODE)) u_dn_match (
    .clk(clk), .rst(rst), .bit_in(rx_bit), .bit_vld(rx_valid), .present(dn_pres));

  lc_qual_timer #(.QUAL_SECS(QUAL_SECS)) u_up_timer (
    .clk(clk), .rst(rst), .clr(tmr_clr), .present(up_pres),
    .tick(sec_tick), .qualified(up_qual));

  lc_qual_timer #(.QUAL_SECS(QUAL_SECS)) u_dn_timer (
    .clk(clk), .rst(rst), .clr(tmr_clr), .present(dn_pres),
    .tick(sec_tick), .qualified(dn_qual));

  lc_ctrl u_ctrl (
    .clk(clk), .rst(rst), .mode_sel(mode_sel), .irq_en(irq_en),
    .up_qual(up_qual), .dn_qual(dn_qual), .tmr_clr(tmr_clr),
    .status(det_status), .loop_on(rloop_en), .irq(irq_pulse));

  // R1
  reset_quiet_chk: assert property (@(posedge clk)
    $past(rst) |-> (!det_status && !rloop_en && !irq_pulse));
  // R6
  irq_gate_chk: assert property (@(posedge clk) disable iff (rst)
    irq_pulse |-> $past(irq_en));
endmodule

// File: tb/tb_loopcode_detect.sv
module tb_loopcode_detect;
  localparam int QS = 2;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       rx_bit = 1'b1;
  logic       rx_valid = 1'b0;
  logic [1:0] mode_sel = 2'b00;
  logic       irq_en = 1'b0;
  logic       sec_tick = 1'b0;
  logic       det_status, rloop_en, irq_pulse;

  int vectors = 0;
  int errors = 0;
  int pat_sel = 0;   // 0: all ones, 1: loop-up, 2: loop-down
  int ph5 = 0;
  int ph3 = 0;
  bit done = 0;
  logic exp_q[$];

  loopcode_detect #(.QUAL_SECS(QS)) dut (
    .clk(clk), .rst(rst), .rx_bit(rx_bit), .rx_valid(rx_valid),
    .mode_sel(mode_sel), .irq_en(irq_en), .sec_tick(sec_tick),
    .det_status(det_status), .rloop_en(rloop_en), .irq_pulse(irq_pulse));

  always #10 clk = ~clk;

  // bit source
  always @(negedge clk) begin
    ph5 = (ph5 == 4) ? 0 : ph5 + 1;
    ph3 = (ph3 == 2) ? 0 : ph3 + 1;
    case (pat_sel)
      1: rx_bit = (ph5 == 4);
      2: rx_bit = (ph3 == 2);
      default: rx_bit = 1'b1;
    endcase
  end

  // monitor: each interrupt pops the expected new status (R6)
  always @(negedge clk) begin
    if (!rst && irq_pulse) begin
      vectors++;
      if (exp_q.size() == 0) begin
        errors++;
        $display("FAIL R6 unexpected irq: act status=%0b exp no irq", det_status);
      end else begin
        logic e;
        e = exp_q.pop_front();
        if (det_status !== e) begin
          errors++;
          $display("FAIL R6 irq status: act=%0b exp=%0b", det_status, e);
        end
      end
    end
  end

  task automatic check(string req, logic act, logic exp);
    vectors++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s act=%0b exp=%0b", req, act, exp);
    end
  endtask

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic ticks(int n);
    repeat (n) begin
      @(negedge clk) sec_tick = 1'b1;
      @(negedge clk) sec_tick = 1'b0;
      idle(8);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      if (exp_q.size() != 0) begin
        errors++;
        $display("FAIL R6 missing irq: act=%0d pending exp=0", exp_q.size());
      end
      $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: act=timeout exp=done");
    finish_run();
  end

  initial begin
    idle(4);
    rst = 1'b0;
    rx_valid = 1'b1;
    idle(1);
    check("R1 status", det_status, 1'b0);
    check("R1 loop", rloop_en, 1'b0);
    check("R1 irq", irq_pulse, 1'b0);

    // manual, loop-up, boundary
    mode_sel = 2'b01; irq_en = 1'b1; pat_sel = 1;
    idle(20);
    ticks(QS);
    check("R2 exactly QS ticks", det_status, 1'b0);
    exp_q.push_back(1'b1);
    ticks(1);
    check("R2 qualified", det_status, 1'b1);
    check("R5 manual no loop", rloop_en, 1'b0);
    exp_q.push_back(1'b0);
    pat_sel = 0; idle(10);
    check("R5 clears on stop", det_status, 1'b0);

    // manual select 10, loop-down
    mode_sel = 2'b10; pat_sel = 2; idle(20);
    ticks(QS);
    check("R3 exactly QS ticks", det_status, 1'b0);
    exp_q.push_back(1'b1);
    ticks(1);
    check("R3 down qualified", det_status, 1'b1);
    exp_q.push_back(1'b0);
    pat_sel = 0; idle(10);
    check("R5 down clears", det_status, 1'b0);

    // break mid-count
    pat_sel = 1; idle(20);
    ticks(QS);
    pat_sel = 0; idle(10);
    pat_sel = 1; idle(20);
    ticks(QS);
    check("R4 restart after break", det_status, 1'b0);
    exp_q.push_back(1'b1);
    ticks(1);
    check("R4 qualifies after restart", det_status, 1'b1);
    exp_q.push_back(1'b0);
    pat_sel = 0; idle(10);

    // interrupts disabled
    irq_en = 1'b0; pat_sel = 1; idle(20);
    ticks(QS + 1);
    check("R6 status without irq", det_status, 1'b1);
    pat_sel = 0; idle(10);
    check("R6 status falls without irq", det_status, 1'b0);
    irq_en = 1'b1;

    // off mode
    mode_sel = 2'b00; pat_sel = 1; idle(20);
    ticks(QS + 3);
    check("R10 off status", det_status, 1'b0);
    check("R10 off loop", rloop_en, 1'b0);

    // automatic
    mode_sel = 2'b11; pat_sel = 2; idle(20);
    ticks(QS + 2);
    check("R7 down ignored status", det_status, 1'b0);
    check("R7 down ignored loop", rloop_en, 1'b0);
    pat_sel = 1; idle(20);
    ticks(QS);
    check("R8 not yet", rloop_en, 1'b0);
    exp_q.push_back(1'b1);
    ticks(1);
    check("R8 loop set", rloop_en, 1'b1);
    check("R8 status set", det_status, 1'b1);
    pat_sel = 0; idle(20);
    ticks(QS + 2);
    check("R8 held loop", rloop_en, 1'b1);
    check("R8 held status", det_status, 1'b1);
    pat_sel = 2; idle(20);
    ticks(QS);
    check("R9 not yet", rloop_en, 1'b1);
    exp_q.push_back(1'b0);
    ticks(1);
    check("R9 loop cleared", rloop_en, 1'b0);
    check("R9 status cleared", det_status, 1'b0);

    // latch again, then leave to off
    pat_sel = 1; idle(20);
    exp_q.push_back(1'b1);
    ticks(QS + 1);
    check("R8 relatch", rloop_en, 1'b1);
    exp_q.push_back(1'b0);
    mode_sel = 2'b00; idle(3);
    check("R10 exit drops loop", rloop_en, 1'b0);
    check("R10 exit drops status", det_status, 1'b0);
    mode_sel = 2'b11; idle(3);
    check("R7 re-entry status", det_status, 1'b0);
    check("R7 re-entry loop", rloop_en, 1'b0);
    idle(5);
    finish_run();
  end
endmodule